// File: doc/BRIEF.md
# Walsh Spectrum Imbalance Engine

The engine holds a truth table of 256 words by 32 bits. Word x holds one output bit f(x) for each of 32 Boolean functions of an 8-bit input x. A start pulse runs the engine once. It computes the full Walsh spectrum W_f(w) = sum over x of (-1)^(f(x) XOR parity(x AND w)) for all 32 functions at once. It does this with an in-place butterfly network that runs over 256 signed words per function. The engine then scans every w to build two results: a summed absolute-imbalance score, and a per-function flag for first-order correlation immunity.

The truth table is written one word per cycle through a load port while the engine is idle. After the done pulse, the results stay frozen until the next start. The caller picks one function with a selector and reads its eight spectrum values at the single-bit masks w = 1, 2, 4, ..., 128. Building tables per key guess and ranking guesses are left to the caller.

Top module: `walsh_imbalance_top`

## Requirements
- R1: After a run, with w1_func_i = f, field k of w1_vals_o holds W_f(2^k) as a 10-bit two's-complement value. Field k sits at bits [10k+9:10k], for k = 0..7.
- R2: A truth-table bit of 0 maps to +1 and a bit of 1 maps to -1. The extremes +256 and -256 are reported exactly: a constant function, a single input bit and its complement all give an extreme value.
- R3: Bit f of immune_o is 1 exactly when W_f(0) = 0 and W_f(2^k) = 0 for all eight k. This is first-order correlation immunity.
- R4: score_o equals the sum of |W_f(w)| over all 256 values of w and all 32 functions. While busy it never decreases.
- R5: busy_o goes high on the edge that samples start_i. done_o is a one-cycle pulse, with busy_o low, exactly 1280 clock cycles after that edge.
- R6: Table writes presented while busy_o is high are ignored. A later run without reloading gives the same results.
- R7: start_i while busy_o is high is ignored. The run in progress keeps its timing and its results.
- R8: After reset: busy_o = 0, done_o = 0, score_o = 0, immune_o = 0.
- R9: A write with load_addr_i = x stores load_data_i bit f as f(x).
- R10: While idle, score_o, immune_o and w1_vals_o hold their values across idle cycles and table writes until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Table word write strobe |
| load_addr_i | input | 8 | Input value x of the word |
| load_data_i | input | 32 | Bit f is f(x) |
| start_i | input | 1 | Start pulse, taken when idle |
| w1_func_i | input | 5 | Function selector for w1_vals_o |
| busy_o | output | 1 | Engine running |
| done_o | output | 1 | One-cycle end-of-run pulse |
| w1_vals_o | output | 80 | Eight signed 10-bit W values at single-bit masks |
| immune_o | output | 32 | First-order immunity flag per function |
| score_o | output | 22 | Summed absolute imbalance |

## Verification
The checker assumes that start_i is a synchronous pulse and that nothing but an accepted start or the run itself changes the results. Its hold property relies on the table not feeding the outputs directly. The latency property counts only starts that arrive while idle, so a start during a run must not restart the count. The stimulus changes inputs only on falling edges, never raises load and start in the same cycle, and puts its mid-run start and table writes strictly inside a busy window.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFORM = 2'd1,
    ST_SCORE = 2'd2
  } wsa_state_e;

  function automatic int coef_width(int n_vars);
    return n_vars + 2;
  endfunction

  function automatic int score_width(int n_vars, int n_funcs);
    return 2 * n_vars + $clog2(n_funcs) + 1;
  endfunction
endpackage

// File: rtl/wsa_table.sv
module wsa_table #(
  parameter int N_VARS  = 8,
  parameter int N_FUNCS = 32,
  localparam int N_PTS  = 1 << N_VARS
) (
  input  logic                              clk_i,
  input  logic                              we_i,
  input  logic [N_VARS-1:0]                 addr_i,
  input  logic [N_FUNCS-1:0]                data_i,
  output logic [N_PTS-1:0][N_FUNCS-1:0]     tbl_o
);
  logic [N_PTS-1:0][N_FUNCS-1:0] mem_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= data_i;
  end

  assign tbl_o = mem_q;
endmodule

// File: rtl/wsa_ctrl.sv
module wsa_ctrl
  import wsa_pkg::*;
#(
  parameter int N_VARS = 8,
  localparam int PW    = (N_VARS > 1) ? $clog2(N_VARS) : 1,
  localparam int JW    = N_VARS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              init_o,
  output logic              xform_o,
  output logic              scan_o,
  output logic [PW-1:0]     pass_o,
  output logic [JW-1:0]     pair_o,
  output logic [N_VARS-1:0] omega_o
);
  localparam logic [PW-1:0] LAST_PASS = PW'(N_VARS - 1);

  wsa_state_e        state_q;
  logic [PW-1:0]     pass_q;
  logic [JW-1:0]     pair_q;
  logic [N_VARS-1:0] omega_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      pair_q  <= '0;
      omega_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_XFORM;
            pass_q  <= '0;
            pair_q  <= '0;
          end
        end
        ST_XFORM: begin
          if (&pair_q) begin
            pair_q <= '0;
            if (pass_q == LAST_PASS) begin
              state_q <= ST_SCORE;
              omega_q <= '0;
            end else begin
              pass_q <= pass_q + 1'b1;
            end
          end else begin
            pair_q <= pair_q + 1'b1;
          end
        end
        ST_SCORE: begin
          if (&omega_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            omega_q <= omega_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign init_o  = (state_q == ST_IDLE) && start_i;
  assign xform_o = (state_q == ST_XFORM);
  assign scan_o  = (state_q == ST_SCORE);
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign pair_o  = pair_q;
  assign omega_o = omega_q;
endmodule

// File: rtl/wsa_bfly.sv
module wsa_bfly #(
  parameter int CW = 10
) (
  input  logic signed [CW-1:0] a_i,
  input  logic signed [CW-1:0] b_i,
  output logic signed [CW-1:0] sum_o,
  output logic signed [CW-1:0] dif_o
);
  assign sum_o = a_i + b_i;
  assign dif_o = a_i - b_i;
endmodule

// File: rtl/wsa_abs_sum.sv
module wsa_abs_sum #(
  parameter int N_FUNCS = 32,
  parameter int CW      = 10,
  localparam int OW     = CW + $clog2(N_FUNCS)
) (
  input  logic [N_FUNCS-1:0][CW-1:0] row_i,
  output logic [OW-1:0]              sum_o
);
  logic [N_FUNCS-1:0][CW-1:0] mag;

  for (genvar f = 0; f < N_FUNCS; f++) begin : g_mag
    assign mag[f] = row_i[f][CW-1] ? (~row_i[f] + 1'b1) : row_i[f];
  end

  always_comb begin
    sum_o = '0;
    for (int f = 0; f < N_FUNCS; f++) sum_o = sum_o + OW'(mag[f]);
  end
endmodule

// File: rtl/walsh_imbalance_top.sv
module walsh_imbalance_top
  import wsa_pkg::*;
#(
  parameter int N_VARS  = 8,
  parameter int N_FUNCS = 32,
  localparam int FW     = $clog2(N_FUNCS),
  localparam int CW     = coef_width(N_VARS),
  localparam int SW     = score_width(N_VARS, N_FUNCS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_en_i,
  input  logic [N_VARS-1:0]    load_addr_i,
  input  logic [N_FUNCS-1:0]   load_data_i,
  input  logic                 start_i,
  input  logic [FW-1:0]        w1_func_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [N_VARS*CW-1:0] w1_vals_o,
  output logic [N_FUNCS-1:0]   immune_o,
  output logic [SW-1:0]        score_o
);
  localparam int N_PTS = 1 << N_VARS;
  localparam int PW    = (N_VARS > 1) ? $clog2(N_VARS) : 1;
  localparam int JW    = N_VARS - 1;
  localparam int AW    = CW + FW;

  logic [N_PTS-1:0][N_FUNCS-1:0] tbl;
  logic              init_en, xform_en, scan_en;
  logic [PW-1:0]     pass;
  logic [JW-1:0]     pair;
  logic [N_VARS-1:0] omega;

  wsa_table #(.N_VARS(N_VARS), .N_FUNCS(N_FUNCS)) i_table (
    .clk_i  (clk_i),
    .we_i   (load_en_i && !busy_o),
    .addr_i (load_addr_i),
    .data_i (load_data_i),
    .tbl_o  (tbl)
  );

  wsa_ctrl #(.N_VARS(N_VARS)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .init_o  (init_en),
    .xform_o (xform_en),
    .scan_o  (scan_en),
    .pass_o  (pass),
    .pair_o  (pair),
    .omega_o (omega)
  );

  // spectrum store, one row of all lanes per point
  logic [N_FUNCS-1:0][CW-1:0] spec_q [N_PTS];

  // butterfly partner indices: insert a zero at bit 'pass' of 'pair'
  logic [N_VARS-1:0] pair_ext, low_mask, lo_idx, hi_idx;
  always_comb begin
    pair_ext = N_VARS'(pair);
    low_mask = (N_VARS'(1) << pass) - 1'b1;
    lo_idx   = ((pair_ext & ~low_mask) << 1) | (pair_ext & low_mask);
    hi_idx   = lo_idx | (N_VARS'(1) << pass);
  end

  logic [N_FUNCS-1:0][CW-1:0] row_lo, row_hi, bf_sum, bf_dif;
  assign row_lo = spec_q[lo_idx];
  assign row_hi = spec_q[hi_idx];

  for (genvar f = 0; f < N_FUNCS; f++) begin : g_lane
    wsa_bfly #(.CW(CW)) i_bfly (
      .a_i   (row_lo[f]),
      .b_i   (row_hi[f]),
      .sum_o (bf_sum[f]),
      .dif_o (bf_dif[f])
    );
  end

  always_ff @(posedge clk_i) begin
    if (init_en) begin
      for (int x = 0; x < N_PTS; x++)
        for (int f = 0; f < N_FUNCS; f++)
          spec_q[x][f] <= tbl[x][f] ? {CW{1'b1}} : CW'(1);
    end else if (xform_en) begin
      spec_q[lo_idx] <= bf_sum;
      spec_q[hi_idx] <= bf_dif;
    end
  end

  // scan phase: magnitude sum and immunity screening
  logic [N_FUNCS-1:0][CW-1:0] row_scan;
  logic [AW-1:0]              row_abs;
  logic                       low_weight;
  assign row_scan   = spec_q[omega];
  assign low_weight = ($countones(omega) <= 1);

  wsa_abs_sum #(.N_FUNCS(N_FUNCS), .CW(CW)) i_abs_sum (
    .row_i (row_scan),
    .sum_o (row_abs)
  );

  logic [SW-1:0]      score_q;
  logic [N_FUNCS-1:0] immune_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_q  <= '0;
      immune_q <= '0;
    end else if (init_en) begin
      score_q  <= '0;
      immune_q <= '1;
    end else if (scan_en) begin
      score_q <= score_q + SW'(row_abs);
      if (low_weight) begin
        for (int f = 0; f < N_FUNCS; f++)
          if (row_scan[f] != '0) immune_q[f] <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < N_VARS; k++) begin : g_w1
    logic [N_FUNCS-1:0][CW-1:0] row_k;
    assign row_k = spec_q[1 << k];
    assign w1_vals_o[k*CW +: CW] = row_k[w1_func_i];
  end

  assign score_o  = score_q;
  assign immune_o = immune_q;
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker #(
  parameter int N_VARS  = 8,
  parameter int N_FUNCS = 32,
  parameter int SW      = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [N_FUNCS-1:0] immune_o,
  input logic [SW-1:0]      score_o
);
  localparam int N_PTS = 1 << N_VARS;
  localparam int LAT   = (N_PTS / 2) * N_VARS + N_PTS;
  localparam logic [SW:0] SCORE_MAX = (SW+1)'(N_FUNCS) * (SW+1)'(N_PTS) * (SW+1)'(N_PTS);

  int unsigned lat_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_cnt <= 0;
    else if (!busy_o && start_i) lat_cnt <= 0;
    else if (busy_o)            lat_cnt <= lat_cnt + 1;
  end

  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt == LAT));
  assert_score_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (score_o >= $past(score_o)));
  assert_score_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, score_o} <= SCORE_MAX);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(score_o) && $stable(immune_o)));
endmodule

bind walsh_imbalance_top wsa_checker #(
  .N_VARS(N_VARS), .N_FUNCS(N_FUNCS), .SW(SW)
) i_wsa_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .immune_o (immune_o),
  .score_o  (score_o)
);

// File: tb/test_walsh_imbalance_top.sv
`timescale 1ns/1ps
module test_walsh_imbalance_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV  = 8;
  localparam int NF  = 32;
  localparam int NP  = 1 << NV;
  localparam int CW  = NV + 2;
  localparam int SW  = 2 * NV + $clog2(NF) + 1;
  localparam int LAT = (NP / 2) * NV + NP;

  typedef struct packed {
    logic [SW-1:0]              score;
    logic [NF-1:0]              ci;
    logic [NF-1:0][NV-1:0][CW-1:0] w1;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic load_en = 0, start = 0;
  logic [NV-1:0] load_addr = '0;
  logic [NF-1:0] load_data = '0;
  logic [$clog2(NF)-1:0] w1_sel = '0;
  logic busy, done;
  logic [NV*CW-1:0] w1_vals;
  logic [NF-1:0] immune;
  logic [SW-1:0] score;

  int checks = 0, errors = 0;
  exp_t sb_q[$];
  logic [NF-1:0] tb_tbl [NP];
  logic [31:0] rng = 32'h1234_5677;

  always #(CLK_PERIOD/2) clk = ~clk;

  walsh_imbalance_top #(.N_VARS(NV), .N_FUNCS(NF)) i_walsh_imbalance_top (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_data_i(load_data), .start_i(start), .w1_func_i(w1_sel),
    .busy_o(busy), .done_o(done), .w1_vals_o(w1_vals), .immune_o(immune),
    .score_o(score)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // direct evaluation of the transform definition
  task automatic compute_expected(output exp_t e);
    e = '0;
    e.ci = '1;
    for (int f = 0; f < NF; f++) begin
      for (int w = 0; w < NP; w++) begin
        int s = 0;
        for (int x = 0; x < NP; x++) begin
          logic b;
          b = tb_tbl[x][f] ^ (^(NV'(x) & NV'(w)));
          s += b ? -1 : 1;
        end
        e.score += SW'(s < 0 ? -s : s);
        if ($countones(NV'(w)) <= 1 && s != 0) e.ci[f] = 1'b0;
        for (int k = 0; k < NV; k++)
          if (w == (1 << k)) e.w1[f][k] = CW'(s);
      end
    end
  endtask

  task automatic load_table();
    for (int x = 0; x < NP; x++) begin
      @(negedge clk);
      load_en = 1; load_addr = NV'(x); load_data = tb_tbl[x];
    end
    @(negedge clk);
    load_en = 0;
  endtask

  // driver: push expectation, start, measure latency; optional busy-time disturbance
  task automatic run_case(input bit disturb);
    exp_t e;
    int n;
    compute_expected(e);
    sb_q.push_back(e);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R5", "busy after start", busy, 1);
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 0; load_en = 0;
      if (done) break;
      if (disturb && n == 300) start = 1;                 // R7 restart attempt
      if (disturb && n >= 100 && n < 164) begin           // R6 writes while busy
        load_en = 1; load_addr = NV'(n); load_data = next_rand();
      end
    end
    check(n == LAT, "R5", "cycles from start to done", n, LAT);
    check(busy === 1'b0, "R5", "busy at done", busy, 0);
    wait (sb_q.size() == 0);
    @(negedge clk);
    check(done === 1'b0, "R5", "done one cycle wide", done, 0);
  endtask

  // monitor: compare against scoreboard on every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done && sb_q.size() != 0) begin
        exp_t e;
        e = sb_q[0];
        check(score == e.score, "R4", "score", score, e.score);
        check(immune == e.ci, "R3", "immunity mask", immune, e.ci);
        for (int f = 0; f < NF; f++) begin
          w1_sel = f[$clog2(NF)-1:0];
          #1;
          for (int k = 0; k < NV; k++)
            check(w1_vals[k*CW +: CW] == e.w1[f][k], "R1", $sformatf("W f%0d mask bit %0d", f, k),
                  $signed(w1_vals[k*CW +: CW]), $signed(e.w1[f][k]));
        end
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [SW-1:0] held_score;
    logic [NF-1:0] held_ci;
    logic [NV*CW-1:0] held_w1;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0, "R8", "busy after reset", busy, 0);
    check(done === 1'b0, "R8", "done after reset", done, 0);
    check(score === '0, "R8", "score after reset", score, 0);
    check(immune === '0, "R8", "immune after reset", immune, 0);

    // constant zero functions: W(0)=+256 (R2)
    for (int x = 0; x < NP; x++) tb_tbl[x] = '0;
    load_table();
    run_case(0);
    check(score == SW'(NF * NP), "R2", "constant-zero score", score, NF * NP);

    // single input bits, upper half complemented: +256 / -256 at w=2^k (R2, R9)
    for (int x = 0; x < NP; x++)
      for (int f = 0; f < NF; f++)
        tb_tbl[x][f] = x[f % NV] ^ (f >= NF/2);
    load_table();
    run_case(0);
    check(immune == '0, "R9", "linear functions not immune", immune, 0);
    check(score == SW'(NF * NP), "R2", "linear score", score, NF * NP);

    // two-bit parities (immune) mixed with random functions (R3)
    for (int x = 0; x < NP; x++) begin
      tb_tbl[x] = next_rand();
      for (int f = 0; f < 8; f++) tb_tbl[x][f] = x[f % NV] ^ x[(f + 3) % NV];
      tb_tbl[x][8] = 1'b1;
    end
    load_table();
    run_case(0);
    check(immune[7:0] == 8'hff, "R3", "parity functions immune", immune[7:0], 8'hff);

    // random table, writes and a restart while busy (R6, R7)
    for (int x = 0; x < NP; x++) tb_tbl[x] = next_rand();
    load_table();
    run_case(1);
    run_case(0);  // R6: table untouched by busy writes, same result

    // idle hold across writes (R10)
    held_score = score; held_ci = immune; held_w1 = w1_vals;
    for (int x = 0; x < 40; x++) begin
      @(negedge clk);
      load_en = 1; load_addr = NV'(x); load_data = next_rand();
    end
    @(negedge clk);
    load_en = 0;
    repeat (10) @(negedge clk);
    check(score == held_score, "R10", "score held", score, held_score);
    check(immune == held_ci, "R10", "immune held", immune, held_ci);
    check(w1_vals == held_w1, "R10", "w1 values held", w1_vals[CW-1:0], held_w1[CW-1:0]);
    check(done === 1'b0 && busy === 1'b0, "R10", "idle flags", {busy, done}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule